// File: doc/BRIEF.md
# SPI Register Access Target

This block lets an external SPI host read and write a bank of 24-bit registers through fixed 32-bit frames. The serial pins are oversampled in the system clock domain. The block decodes each frame and presents a plain register-bank interface (address, write strobe, write data, read data) to the fabric around it. Frames use SPI mode 0: the clock idles low, the host samples on the rising edge, and the target updates its output after the falling edge. Chip select is active high, and a frame exists only while it is high.

The first bit of a frame is the direction bit. The next bits are a 6-bit register address, then one spare bit, then 24 data bits. As soon as the last address bit is in, the addressed register is read from the bank and loaded into a transmit shifter. The host therefore receives the register contents in the last 24 bit times of the same frame. A write reaches the bank only when chip select drops after exactly 32 rising clock edges, so a frame that is too short or too long leaves no trace. With default parameters, each SCK phase must last at least 8 system clock cycles, and chip select must stay low for at least 4 cycles between frames.

Top module: `spi_reg_port`

## Requirements
- R1: A frame is shifted in MSB first on rising SCK edges while CS is high. Frame bit 31 is the direction (1 = write, 0 = read). Bits 30..25 are the register address, and bits 23..0 are the data field.
- R2: When CS falls after exactly 32 rising SCK edges of a write frame, `reg_wr_en` pulses for one cycle. During that pulse, `reg_addr` holds the frame address and `reg_wr_data` holds frame bits 23..0. `reg_addr` is stable during the pulse.
- R3: A read frame never raises `reg_wr_en`, whatever the host sends in its data field.
- R4: In every complete frame, MISO returns 0 for frame bits 31..24 and returns the addressed register's prior contents, MSB first, in bits 23..0. Each bit changes after a falling SCK edge.
- R5: MISO is held low while CS is low.
- R6: A frame with any count of rising SCK edges other than 32 is discarded. It produces no write strobe and no `frame_done`.
- R7: `frame_done` is a single-cycle pulse after every complete 32-bit frame, read or write. It occurs only after CS has gone low, and it coincides with `reg_wr_en` on writes.
- R8: While reset is high, and in the cycle after it, `reg_wr_en`, `frame_done` and `spi_miso` are 0 and `reg_addr` is 0.
- R9: Frame bit 24 is ignored. A write with bit 24 set commits the same data as one with it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low when deselected |
| reg_addr | output | 6 | Register address captured from the frame |
| reg_wr_en | output | 1 | One-cycle write strobe to the bank |
| reg_wr_data | output | 24 | Data to write |
| reg_rd_data | input | 24 | Bank read data, one cycle after `reg_addr` |
| frame_done | output | 1 | One-cycle pulse at the end of a complete frame |

## Verification
A wrong bit counter or frame phase shows at the ports within one frame. A good-length frame loses its `frame_done`, a bad-length frame commits a write, or the returned data field is shifted by one position. A wrong address capture or a late load of the transmit shifter shows in the 24 returned bits of the same frame. A wrong committed value shows in the next read-back of that address. A transmit register that is not cleared shows as MISO activity in the idle cycles between frames, and those cycles are compared every clock.

// File: rtl/spi_reg_port_pkg.sv
package spi_reg_port_pkg;

  // Position of the receiver inside a frame.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,  // chip select low
    PH_HEADER  = 2'd1,  // direction, address and spare bit
    PH_PAYLOAD = 2'd2,  // data field
    PH_OVERRUN = 2'd3   // more clocks than a frame holds
  } frame_phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings asynchronous pins into the clk domain and, for the low EDGE_W
// bits, produces single-cycle rise and fall pulses.
module spi_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int EDGE_W = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  level,
  output logic [EDGE_W-1:0] rise,
  output logic [EDGE_W-1:0] fall
);

  logic [STAGES-1:0][WIDTH-1:0] chain;
  logic [EDGE_W-1:0]            prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1][EDGE_W-1:0];
  end

  assign level = chain[STAGES-1];
  assign rise  =  level[EDGE_W-1:0] & ~prev;
  assign fall  = ~level[EDGE_W-1:0] &  prev;

endmodule

// File: rtl/spi_frame_rx.sv
// Counts rising SCK edges, captures direction and address, and decides
// at deselect whether the frame was complete.
module spi_frame_rx
  import spi_reg_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PAD_W  = 1,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              mosi_lvl,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_cap,
  output logic              in_payload,
  output logic              frame_end,
  output logic              wr_commit,
  output logic [DATA_W-1:0] data_q
);

  localparam int HDR_W   = 1 + ADDR_W + PAD_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_DIR  = '0;
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  frame_phase_e       phase;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] rx_sr;
  logic               dir_q;
  logic               counting;

  assign counting   = cs_lvl && sck_rise &&
                      (phase == PH_HEADER || phase == PH_PAYLOAD);
  assign in_payload = (phase == PH_PAYLOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rx_sr     <= '0;
      dir_q     <= 1'b0;
      addr_q    <= '0;
      addr_cap  <= 1'b0;
      frame_end <= 1'b0;
      wr_commit <= 1'b0;
      data_q    <= '0;
    end else begin
      addr_cap  <= 1'b0;
      frame_end <= 1'b0;
      wr_commit <= 1'b0;
      if (cs_rise) begin
        phase <= PH_HEADER;
        cnt   <= '0;
      end else if (cs_fall) begin
        phase <= PH_IDLE;
        if (phase == PH_PAYLOAD && cnt == CNT_FULL) begin
          frame_end <= 1'b1;
          wr_commit <= dir_q;
          data_q    <= rx_sr[DATA_W-1:0];
        end
      end else if (counting) begin
        rx_sr <= {rx_sr[FRAME_W-2:0], mosi_lvl};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_DIR) dir_q <= mosi_lvl;
        if (cnt == CNT_ADDR) begin
          addr_q   <= {rx_sr[ADDR_W-2:0], mosi_lvl};
          addr_cap <= 1'b1;
        end
        if (cnt == CNT_HDR)  phase <= PH_PAYLOAD;
        if (cnt == CNT_FULL) phase <= PH_OVERRUN;
      end
    end
  end

endmodule

// File: rtl/spi_frame_tx.sv
// Loads the bank read data once the address is known and shifts it out
// on falling SCK edges during the data field.
module spi_frame_tx #(
  parameter int DATA_W     = 24,
  parameter int RD_LATENCY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              sck_fall,
  input  logic              shift_en,
  input  logic              load_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso
);

  logic [RD_LATENCY:0] ld_pipe;
  logic [RD_LATENCY:0] ld_next;
  logic [DATA_W-1:0]   tx_sr;

  always_comb begin
    ld_next    = ld_pipe << 1;
    ld_next[0] = load_req;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_lvl || cs_rise) begin
      ld_pipe <= '0;
      tx_sr   <= '0;
      miso    <= 1'b0;
    end else begin
      ld_pipe <= ld_next;
      if (ld_pipe[RD_LATENCY]) begin
        tx_sr <= rd_data;
      end else if (sck_fall && shift_en) begin
        miso  <= tx_sr[DATA_W-1];
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int ADDR_W      = 6,
  parameter int PAD_W       = 1,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LATENCY  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              frame_done
);

  localparam int PIN_W  = 3;
  localparam int EDGE_W = 2;
  localparam int P_CS   = 0;
  localparam int P_SCK  = 1;
  localparam int P_MOSI = 2;

  logic [PIN_W-1:0]  pin_lvl;
  logic [EDGE_W-1:0] pin_rise;
  logic [EDGE_W-1:0] pin_fall;
  logic              addr_cap;
  logic              in_payload;

  spi_pin_sync #(
    .WIDTH (PIN_W),
    .EDGE_W(EDGE_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_mosi, spi_sck, spi_cs}),
    .level(pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  spi_frame_rx #(
    .ADDR_W(ADDR_W),
    .PAD_W (PAD_W),
    .DATA_W(DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (pin_lvl[P_CS]),
    .cs_rise   (pin_rise[P_CS]),
    .cs_fall   (pin_fall[P_CS]),
    .sck_rise  (pin_rise[P_SCK]),
    .mosi_lvl  (pin_lvl[P_MOSI]),
    .addr_q    (reg_addr),
    .addr_cap  (addr_cap),
    .in_payload(in_payload),
    .frame_end (frame_done),
    .wr_commit (reg_wr_en),
    .data_q    (reg_wr_data)
  );

  spi_frame_tx #(
    .DATA_W    (DATA_W),
    .RD_LATENCY(RD_LATENCY)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .cs_lvl  (pin_lvl[P_CS]),
    .cs_rise (pin_rise[P_CS]),
    .sck_fall(pin_fall[P_SCK]),
    .shift_en(in_payload),
    .load_req(addr_cap),
    .rd_data (reg_rd_data),
    .miso    (spi_miso)
  );

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs,
  input logic              spi_miso,
  input logic              reg_wr_en,
  input logic              frame_done,
  input logic [ADDR_W-1:0] reg_addr
);

  // R2
  wr_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> frame_done);

  // R2
  addr_stable_on_wr_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $stable(reg_addr));

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R7
  done_after_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !$past(spi_cs));

  // R5
  miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs && !$past(spi_cs) && !$past(spi_cs, 2) && !$past(spi_cs, 3))
      |-> !spi_miso);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!reg_wr_en && !frame_done && !spi_miso && reg_addr == '0));

endmodule

bind spi_reg_port spi_reg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_cs    (spi_cs),
  .spi_miso  (spi_miso),
  .reg_wr_en (reg_wr_en),
  .frame_done(frame_done),
  .reg_addr  (reg_addr)
);

// File: tb/test_spi_reg_port.sv
`timescale 1ns/1ps
module test_spi_reg_port;

  localparam int HP = 8;  // SCK half period in clk cycles

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0;
  logic        spi_cs = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [5:0]  reg_addr;
  logic        reg_wr_en;
  logic [23:0] reg_wr_data;
  logic [23:0] reg_rd_data;
  logic        frame_done;

  int n_cmp = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int cs_low = 0;
  logic [5:0]  last_wr_addr;
  logic [23:0] last_wr_data;
  logic [23:0] bank [64];
  logic [23:0] model [64];

  always #5 clk = ~clk;

  spi_reg_port i_spi_reg_port (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .frame_done(frame_done)
  );

  // Register bank attached to the port, one cycle read latency.
  always @(posedge clk) begin
    if (reg_wr_en) bank[reg_addr] <= reg_wr_data;
    reg_rd_data <= bank[reg_addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Every-clock comparison: idle MISO and strobe bookkeeping.
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_cs) cs_low = 0; else cs_low++;
      if (cs_low >= 4)
        check(spi_miso == 1'b0, "R5", "miso while deselected",
              {31'b0, spi_miso}, 32'h0);
      if (reg_wr_en) begin
        wr_cnt++;
        last_wr_addr = reg_addr;
        last_wr_data = reg_wr_data;
      end
      if (frame_done) done_cnt++;
    end
  end

  task automatic ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic run_frame(input logic [31:0] word, input int nbits,
                           output logic [31:0] got);
    got = '0;
    spi_cs = 1'b1;
    ticks(HP);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 32) ? word[31 - i] : 1'b0;
      ticks(HP);
      if (i < 32) got[31 - i] = spi_miso;
      spi_sck = 1'b1;
      ticks(HP);
      spi_sck = 1'b0;
    end
    ticks(HP);
    spi_cs = 1'b0;
    spi_mosi = 1'b0;
    ticks(12);
  endtask

  task automatic do_read(input logic [5:0] a, input logic [23:0] junk);
    logic [31:0] got;
    int w0 = wr_cnt;
    int d0 = done_cnt;
    run_frame({1'b0, a, 1'b0, junk}, 32, got);
    check(got[31:24] == 8'h0, "R4", "read header bits", got[31:24], 32'h0);
    check(got[23:0] == model[a], "R4", "read data", got[23:0], model[a]);
    check(wr_cnt == w0, "R3", "no strobe on read", wr_cnt - w0, 0);
    check(done_cnt == d0 + 1, "R7", "done on read", done_cnt - d0, 1);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [23:0] d,
                          input logic pad, input string req);
    logic [31:0] got;
    int w0 = wr_cnt;
    int d0 = done_cnt;
    run_frame({1'b1, a, pad, d}, 32, got);
    check(got[23:0] == model[a], "R4", "old data on write", got[23:0], model[a]);
    check(wr_cnt == w0 + 1, "R2", "one strobe", wr_cnt - w0, 1);
    check(done_cnt == d0 + 1, "R7", "done on write", done_cnt - d0, 1);
    check(last_wr_addr == a, req, "write address", last_wr_addr, a);
    check(last_wr_data == d, req, "write data", last_wr_data, d);
    model[a] = d;
  endtask

  task automatic bad_frame(input logic [31:0] word, input int nbits);
    logic [31:0] got;
    int w0 = wr_cnt;
    int d0 = done_cnt;
    run_frame(word, nbits, got);
    check(wr_cnt == w0, "R6", $sformatf("no strobe %0d bits", nbits),
          wr_cnt - w0, 0);
    check(done_cnt == d0, "R6", $sformatf("no done %0d bits", nbits),
          done_cnt - d0, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      bank[i]  = 24'(i * 32'h010203) ^ 24'h5A5A5A;
      model[i] = 24'(i * 32'h010203) ^ 24'h5A5A5A;
    end
    ticks(3);
    // R8: outputs during reset
    check(!reg_wr_en && !frame_done && !spi_miso && reg_addr == 6'd0,
          "R8", "reset outputs",
          {reg_addr, reg_wr_en, frame_done, spi_miso}, 32'h0);
    rst = 1'b0;
    ticks(4);
    check(!reg_wr_en && !frame_done && !spi_miso && reg_addr == 6'd0,
          "R8", "after reset",
          {reg_addr, reg_wr_en, frame_done, spi_miso}, 32'h0);

    do_read(6'h00, 24'h0);
    do_read(6'h3F, 24'h0);
    do_read(6'h05, 24'hFFFFFF);              // R3: junk in data field
    do_write(6'h3F, 24'hABCDEF, 1'b0, "R1");
    do_read(6'h3F, 24'h0);
    do_write(6'h00, 24'h000001, 1'b0, "R1");
    do_write(6'h2A, 24'h800000, 1'b1, "R9"); // bit 24 set
    do_read(6'h2A, 24'h0);
    do_read(6'h00, 24'h0);
    // R6: short, long and aborted write frames
    bad_frame({1'b1, 6'h2A, 1'b0, 24'h123456}, 31);
    bad_frame({1'b1, 6'h2A, 1'b0, 24'h654321}, 33);
    bad_frame({1'b1, 6'h2A, 1'b0, 24'h777777}, 7);
    do_read(6'h2A, 24'h0);
    for (int k = 1; k < 8; k++) begin
      logic [5:0]  a = 6'((k * 9) % 64);
      logic [23:0] d = 24'(k * 32'h135791) ^ 24'hC3C3C3;
      do_write(a, d, 1'(k & 1), (k & 1) ? "R9" : "R2");
      do_read(a, 24'(k));
    end
    do_read(6'h3F, 24'h0);
    finish_run();
  end

endmodule